// File: doc/BRIEF.md
# Dual-Predictor Confidence Selector

This block arbitrates between two value predictors that run side by side. One component is keyed by operand values (it receives the XOR of the two source operands). The other is keyed by the instruction address. For each accepted request, the selector computes which components may predict that instruction type under the current routing mode. It strobes those components in the same cycle and compares the confidence each one returns. It then registers a single predicted value, together with a predict-enable flag and a tag that names the component that supplied it. The update path can use the tag to train the correct component.

Requests enter on a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The component responses (`opx_*`, `adx_*`) are combinational answers to the lookup strobes in that same cycle. The result appears on the output handshake on the following cycle. The result stays on the output until `pred_ready` takes it. While a result is held and `pred_ready` is low, `req_ready` is low and no lookup is issued. The routing mode is a plain control input and is sampled when a request is accepted.

Top module: `vp_dual_select`

## Requirements
- R1: After reset, `pred_valid` is 0 and `req_ready` is 1. With `req_valid` low, neither lookup strobe is active.
- R2: A request accepted at a clock edge produces `pred_valid`=1 after that edge. While `pred_ready` is 0, `pred_valid`, `pred_en`, `pred_src` and `pred_value` hold their values.
- R3: Lookup strobes fire only in the cycle a request is accepted, and only for the eligible components. Both components are looked up in parallel. `opx_key` equals `req_opa ^ req_opb` and `adx_pc` equals `req_pc`.
- R4: Instruction types are encoded as follows: 0 load, 1 integer ALU, 2 store, 3 multiply/divide, 4 to 7 other. With `cfg_mode`=0, both components are eligible for loads and ALU operations.
- R5: With `cfg_mode`=1, the operand-keyed component is eligible only for loads, and the address-keyed component is eligible for loads and ALU operations.
- R6: With `cfg_mode`=2, the operand-keyed component is eligible only for loads, and the address-keyed component is eligible only for ALU operations.
- R7: Types 2 to 7 are never predicted. No strobe fires for them, and `pred_en`=0.
- R8: When both components qualify (eligible and hit), the one with the strictly higher confidence supplies `pred_value`. `pred_src` is 1 for the operand-keyed component and 0 for the address-keyed component.
- R9: When both qualify with equal confidence, the address-keyed component wins (`pred_src`=0).
- R10: If only one component qualifies, it supplies the value. If none qualifies, `pred_en`=0, `pred_src`=0 and `pred_value`=0.
- R11: While a result is held with `pred_ready` low, `req_ready` is 0. A new request is accepted in the same cycle that the held result is taken.
- R12: With `cfg_mode`=3, neither component is eligible, so nothing is predicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Routing mode (0 to 3) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_itype | input | 3 | Instruction type code |
| req_pc | input | AW | Instruction address |
| req_opa | input | DW | First source operand value |
| req_opb | input | DW | Second source operand or offset |
| opx_lookup | output | 1 | Lookup strobe to the operand-keyed component |
| opx_key | output | DW | Operand-derived key |
| opx_hit | input | 1 | Operand-keyed component has a prediction |
| opx_conf | input | CW | Operand-keyed confidence |
| opx_value | input | DW | Operand-keyed predicted value |
| adx_lookup | output | 1 | Lookup strobe to the address-keyed component |
| adx_pc | output | AW | Address key |
| adx_hit | input | 1 | Address-keyed component has a prediction |
| adx_conf | input | CW | Address-keyed confidence |
| adx_value | input | DW | Address-keyed predicted value |
| pred_valid | output | 1 | Result valid |
| pred_ready | input | 1 | Result accepted by the consumer |
| pred_en | output | 1 | A prediction is offered |
| pred_value | output | DW | Predicted value |
| pred_src | output | 1 | 1 = operand-keyed, 0 = address-keyed |

## Verification
The assertions assume that the component responses are meaningful only while the matching lookup strobe is high. They also assume that `req_*` inputs are settled before the accepting edge. The bench stubs answer combinationally from a per-test setting and change every input only at the falling edge. The confidence comparison assertions rely on the selector ignoring hit flags from strobes that are not active, so the stimulus also drives asserted hit flags for ineligible components, to show that those flags are discarded.

// File: rtl/vp_sel_pkg.sv
package vp_sel_pkg;
  localparam logic [2:0] IT_LOAD   = 3'd0;
  localparam logic [2:0] IT_ALU    = 3'd1;
  localparam logic [2:0] IT_STORE  = 3'd2;
  localparam logic [2:0] IT_MULDIV = 3'd3;

  localparam logic [1:0] MODE_ALL      = 2'd0;
  localparam logic [1:0] MODE_LDOP     = 2'd1;
  localparam logic [1:0] MODE_SPLIT    = 2'd2;
  localparam logic [1:0] MODE_OFF      = 2'd3;

  localparam logic SRC_ADDR = 1'b0;
  localparam logic SRC_OPND = 1'b1;
endpackage

// File: rtl/vp_route.sv
module vp_route
  import vp_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [2:0] itype,
  output logic       op_elig,
  output logic       ad_elig
);
  logic is_ld, is_alu;

  always_comb begin
    is_ld  = (itype == IT_LOAD);
    is_alu = (itype == IT_ALU);
    op_elig = 1'b0;
    ad_elig = 1'b0;
    case (mode)
      MODE_ALL: begin
        op_elig = is_ld | is_alu;
        ad_elig = is_ld | is_alu;
      end
      MODE_LDOP: begin
        op_elig = is_ld;
        ad_elig = is_ld | is_alu;
      end
      MODE_SPLIT: begin
        op_elig = is_ld;
        ad_elig = is_alu;
      end
      default: begin
        op_elig = 1'b0;
        ad_elig = 1'b0;
      end
    endcase
  end

  // R7: stores, mul/div and other types never become eligible
  a_r7_never_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (itype > IT_ALU) |-> (!op_elig && !ad_elig));
  // R12: mode 3 gates everything
  a_r12_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> (!op_elig && !ad_elig));
  // R6: in split mode the two components never share a type
  a_r6_split_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT) |-> !(op_elig && ad_elig));
endmodule

// File: rtl/vp_pick.sv
module vp_pick
  import vp_sel_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_ok,
  input  logic [CW-1:0] op_conf,
  input  logic [DW-1:0] op_val,
  input  logic          ad_ok,
  input  logic [CW-1:0] ad_conf,
  input  logic [DW-1:0] ad_val,
  output logic          sel_en,
  output logic          sel_src,
  output logic [DW-1:0] sel_val
);
  logic take_op;

  always_comb begin
    take_op = op_ok && (!ad_ok || (op_conf > ad_conf));
    sel_en  = op_ok | ad_ok;
    sel_src = take_op ? SRC_OPND : SRC_ADDR;
    if (take_op)    sel_val = op_val;
    else if (ad_ok) sel_val = ad_val;
    else            sel_val = '0;
  end

  // R9: a tie goes to the address-keyed component
  a_r9_tie_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ok && ad_ok && (op_conf == ad_conf)) |-> (sel_src == SRC_ADDR && sel_val == ad_val));
  // R8: a weaker component never supplies the value
  a_r8_no_weaker: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ok && ad_ok && (op_conf < ad_conf)) |-> (sel_val == ad_val));
  // R10: nothing qualifies, nothing offered
  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ok && !ad_ok) |-> (!sel_en && sel_val == '0));
endmodule

// File: rtl/vp_dual_select.sv
module vp_dual_select
  import vp_sel_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_itype,
  input  logic [AW-1:0] req_pc,
  input  logic [DW-1:0] req_opa,
  input  logic [DW-1:0] req_opb,
  output logic          opx_lookup,
  output logic [DW-1:0] opx_key,
  input  logic          opx_hit,
  input  logic [CW-1:0] opx_conf,
  input  logic [DW-1:0] opx_value,
  output logic          adx_lookup,
  output logic [AW-1:0] adx_pc,
  input  logic          adx_hit,
  input  logic [CW-1:0] adx_conf,
  input  logic [DW-1:0] adx_value,
  output logic          pred_valid,
  input  logic          pred_ready,
  output logic          pred_en,
  output logic [DW-1:0] pred_value,
  output logic          pred_src
);
  logic          op_elig, ad_elig, accept;
  logic          sel_en, sel_src;
  logic [DW-1:0] sel_val;
  logic          pv_q, en_q, src_q;
  logic [DW-1:0] val_q;

  vp_route u_route (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .itype(req_itype),
    .op_elig(op_elig), .ad_elig(ad_elig)
  );

  assign req_ready  = !pv_q || pred_ready;
  assign accept     = req_valid && req_ready;
  assign opx_lookup = accept && op_elig;
  assign adx_lookup = accept && ad_elig;
  assign opx_key    = req_opa ^ req_opb;
  assign adx_pc     = req_pc;

  vp_pick #(.DW(DW), .CW(CW)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .op_ok(opx_lookup && opx_hit), .op_conf(opx_conf), .op_val(opx_value),
    .ad_ok(adx_lookup && adx_hit), .ad_conf(adx_conf), .ad_val(adx_value),
    .sel_en(sel_en), .sel_src(sel_src), .sel_val(sel_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      en_q  <= 1'b0;
      src_q <= SRC_ADDR;
      val_q <= '0;
    end else if (accept) begin
      pv_q  <= 1'b1;
      en_q  <= sel_en;
      src_q <= sel_src;
      val_q <= sel_val;
    end else if (pred_ready) begin
      pv_q  <= 1'b0;
    end
  end

  assign pred_valid = pv_q;
  assign pred_en    = en_q;
  assign pred_src   = src_q;
  assign pred_value = val_q;

  // R2: one cycle from acceptance to result
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pred_valid);
  // R2: a stalled result does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready) |=> (pred_valid && $stable(pred_value) &&
                                     $stable(pred_en) && $stable(pred_src)));
  // R11: no new request while the output is blocked
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready) |-> !req_ready);
  // R3: strobes only with a live request
  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (opx_lookup || adx_lookup) |-> req_valid);
endmodule

// File: tb/vp_dual_select_tb_top.sv
`timescale 1ns/1ps
module vp_dual_select_tb_top;
  localparam int DW = 32, AW = 32, CW = 4;
  localparam int NV = 17;
  // {mode, itype, op_hit, op_conf, ad_hit, ad_conf, exp_oplk, exp_adlk, exp_en, exp_src}
  localparam logic [18:0] VEC [NV] = '{
    {2'd0,3'd0,1'b1,4'd9, 1'b1,4'd5, 1'b1,1'b1,1'b1,1'b1},  // R4 R8 op higher
    {2'd0,3'd1,1'b1,4'd3, 1'b1,4'd12,1'b1,1'b1,1'b1,1'b0},  // R4 R8 addr higher
    {2'd0,3'd0,1'b1,4'd7, 1'b1,4'd7, 1'b1,1'b1,1'b1,1'b0},  // R9 tie
    {2'd0,3'd1,1'b0,4'd15,1'b1,4'd2, 1'b1,1'b1,1'b1,1'b0},  // R10 op misses
    {2'd0,3'd1,1'b1,4'd4, 1'b0,4'd15,1'b1,1'b1,1'b1,1'b1},  // R10 addr misses
    {2'd0,3'd0,1'b0,4'd9, 1'b0,4'd9, 1'b1,1'b1,1'b0,1'b0},  // R10 both miss
    {2'd1,3'd1,1'b1,4'd15,1'b1,4'd1, 1'b0,1'b1,1'b1,1'b0},  // R5 op not for ALU
    {2'd1,3'd0,1'b1,4'd10,1'b1,4'd9, 1'b1,1'b1,1'b1,1'b1},  // R5 load both
    {2'd1,3'd1,1'b1,4'd15,1'b0,4'd0, 1'b0,1'b1,1'b0,1'b0},  // R5 R10
    {2'd2,3'd0,1'b0,4'd0, 1'b1,4'd15,1'b1,1'b0,1'b0,1'b0},  // R6 addr not for load
    {2'd2,3'd0,1'b1,4'd2, 1'b1,4'd15,1'b1,1'b0,1'b1,1'b1},  // R6
    {2'd2,3'd1,1'b1,4'd15,1'b1,4'd3, 1'b0,1'b1,1'b1,1'b0},  // R6
    {2'd0,3'd2,1'b1,4'd15,1'b1,4'd15,1'b0,1'b0,1'b0,1'b0},  // R7 store
    {2'd0,3'd3,1'b1,4'd15,1'b1,4'd15,1'b0,1'b0,1'b0,1'b0},  // R7 muldiv
    {2'd3,3'd0,1'b1,4'd15,1'b1,4'd15,1'b0,1'b0,1'b0,1'b0},  // R12
    {2'd0,3'd5,1'b1,4'd15,1'b1,4'd15,1'b0,1'b0,1'b0,1'b0},  // R7 other
    {2'd1,3'd0,1'b1,4'd0, 1'b1,4'd0, 1'b1,1'b1,1'b1,1'b0}   // R9 tie at zero
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_itype = '0;
  logic [AW-1:0] req_pc = '0;
  logic [DW-1:0] req_opa = '0, req_opb = '0;
  logic opx_lookup, adx_lookup, opx_hit, adx_hit;
  logic [DW-1:0] opx_key, opx_value, adx_value;
  logic [AW-1:0] adx_pc;
  logic [CW-1:0] opx_conf, adx_conf;
  logic pred_valid, pred_ready = 1'b1, pred_en, pred_src;
  logic [DW-1:0] pred_value;
  logic st_oh = 1'b0, st_ah = 1'b0;
  logic [CW-1:0] st_oc = '0, st_ac = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // component stubs
  assign opx_hit   = st_oh;
  assign opx_conf  = st_oc;
  assign opx_value = opx_key + 32'd1;
  assign adx_hit   = st_ah;
  assign adx_conf  = st_ac;
  assign adx_value = adx_pc ^ 32'hFFFF_0000;

  vp_dual_select #(.DW(DW), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_itype(req_itype),
    .req_pc(req_pc), .req_opa(req_opa), .req_opb(req_opb),
    .opx_lookup(opx_lookup), .opx_key(opx_key), .opx_hit(opx_hit),
    .opx_conf(opx_conf), .opx_value(opx_value),
    .adx_lookup(adx_lookup), .adx_pc(adx_pc), .adx_hit(adx_hit),
    .adx_conf(adx_conf), .adx_value(adx_value),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_en(pred_en),
    .pred_value(pred_value), .pred_src(pred_src)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_val(input logic en, input logic src,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic [AW-1:0] pc);
    if (!en) return '0;
    return src ? ((a ^ b) + 32'd1) : (pc ^ 32'hFFFF_0000);
  endfunction

  task automatic setup(input logic [18:0] v, input int k);
    cfg_mode  = v[18:17];
    req_itype = v[16:14];
    st_oh = v[13]; st_oc = v[12:9];
    st_ah = v[8];  st_ac = v[7:4];
    req_opa = 32'h0000_1000 + k * 3;
    req_opb = 32'h0F0F_0000 + k;
    req_pc  = 32'h0040_0000 + k * 4;
    req_valid = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    logic [DW-1:0] ea, eb;
    logic [AW-1:0] ep;
    repeat (3) @(negedge clk);
    chk(pred_valid == 1'b0, "R1 pred_valid in reset", pred_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pred_valid == 1'b0 && req_ready == 1'b1, "R1 idle after reset", {pred_valid, req_ready}, 2'b01);
    chk(!opx_lookup && !adx_lookup, "R1 no strobe idle", {opx_lookup, adx_lookup}, 0);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i], i);
      #1;
      chk(opx_lookup == VEC[i][3] && adx_lookup == VEC[i][2],
          $sformatf("R3 R4 R5 R6 R7 R12 strobes vec %0d", i),
          {opx_lookup, adx_lookup}, VEC[i][3:2]);
      chk(opx_key == (req_opa ^ req_opb) && adx_pc == req_pc,
          $sformatf("R3 keys vec %0d", i), opx_key, req_opa ^ req_opb);
      ea = req_opa; eb = req_opb; ep = req_pc;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(pred_valid == 1'b1, $sformatf("R2 latency vec %0d", i), pred_valid, 1);
      chk(pred_en == VEC[i][1] && pred_src == VEC[i][0],
          $sformatf("R8 R9 R10 en/src vec %0d", i), {pred_en, pred_src}, VEC[i][1:0]);
      chk(pred_value == exp_val(VEC[i][1], VEC[i][0], ea, eb, ep),
          $sformatf("R8 R10 value vec %0d", i), pred_value,
          exp_val(VEC[i][1], VEC[i][0], ea, eb, ep));
    end
    @(negedge clk);
    chk(pred_valid == 1'b0, "R2 drained", pred_valid, 0);

    // back-pressure: A held, B waits
    pred_ready = 1'b0;
    setup(VEC[0], 40);
    ea = req_opa; eb = req_opb;
    @(posedge clk);
    @(negedge clk);
    setup(VEC[1], 41);
    ep = req_pc;
    #1;
    chk(req_ready == 1'b0, "R11 ready low while held", req_ready, 0);
    chk(!opx_lookup && !adx_lookup, "R11 no lookup while held", {opx_lookup, adx_lookup}, 0);
    @(posedge clk);
    @(negedge clk);
    chk(pred_valid && pred_src == 1'b1 && pred_value == exp_val(1'b1, 1'b1, ea, eb, '0),
        "R2 hold under stall", pred_value, exp_val(1'b1, 1'b1, ea, eb, '0));
    pred_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1 && opx_lookup && adx_lookup, "R11 accept on drain",
        {req_ready, opx_lookup, adx_lookup}, 3'b111);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pred_valid && pred_src == 1'b0 && pred_value == exp_val(1'b1, 1'b0, '0, '0, ep),
        "R11 second result", pred_value, exp_val(1'b1, 1'b0, '0, '0, ep));
    @(negedge clk);
    chk(pred_valid == 1'b0, "R2 empty after drain", pred_valid, 0);

    // reset mid-flight clears output
    setup(VEC[0], 50);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(pred_valid == 1'b0 && req_ready == 1'b1, "R1 reset clears result", {pred_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end
endmodule